// File: doc/BRIEF.md
# Diode-Emulation Mode Selector

This block sits in the control path of a synchronous buck converter. Once per PWM pulse it decides whether the low-side switch may carry negative inductor current. A level input locks the converter into forced-continuous conduction. When that lock is released, the block picks between continuous conduction and diode emulation from the phase-node polarity sampled at the end of each pulse.

The block switches to diode emulation only after a streak of eight positive-polarity samples. A single negative sample returns it to continuous conduction. While diode emulation is active, the low-side qualifier drops whenever the polarity flag reports reverse current.

A separate minimum-frequency watchdog counts clock cycles since the last pulse. If the gap grows long enough that the switching rate would fall into the audible band, it requests one extra pulse.

Top module: `dem_mode_ctl`

## Requirements
- R1: After reset, `dem_active` is 0, `ls_allow` is 1 and `force_pulse` is 0, and the positive-sample streak is empty.
- R2: While `ccm_lock` is 1, `dem_active` stays 0 and `ls_allow` stays 1, whatever `pulse_end` and `phase_pos` do.
- R3: With `ccm_lock` at 0, a streak of eight `pulse_end` strobes that all carry `phase_pos`=1 (1 means negative inductor current) raises `dem_active` one cycle after the edge that captures the eighth strobe.
- R4: A `pulse_end` strobe with `phase_pos`=0 empties the streak. Seven positives, then one negative, then seven positives leave `dem_active` at 0.
- R5: While `dem_active` is 1, a `pulse_end` strobe with `phase_pos`=0 clears `dem_active` one cycle later. A fresh streak of eight positives is then needed to return.
- R6: `ls_allow` is 0 exactly when `dem_active` is 1 and `phase_pos` is 1, in the same cycle; otherwise it is 1.
- R7: Raising `ccm_lock` while `dem_active` is 1 clears `dem_active` one cycle later and empties the streak. After the lock is released, eight new positives are needed.
- R8: `force_pulse` goes high for one cycle when `AUDIO_LIMIT` cycles have passed since the edge that captured the last strobe or the last forced request. The count then starts again.
- R9: Strobes spaced closer than `AUDIO_LIMIT` cycles never produce `force_pulse`, and the cycle after any captured strobe has `force_pulse` at 0.
- R10: `phase_pos` has no effect on the streak or on `dem_active` in cycles where `pulse_end` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ccm_lock | input | 1 | 1 locks forced-continuous conduction; 0 permits diode emulation |
| pulse_end | input | 1 | One-cycle strobe at the end of each PWM pulse |
| phase_pos | input | 1 | Sampled phase polarity; 1 means negative inductor current |
| dem_active | output | 1 | Diode emulation is in force |
| ls_allow | output | 1 | Low-side switch may conduct |
| force_pulse | output | 1 | One-cycle request for an extra PWM pulse |

## Verification
`dem_active` and `force_pulse` are registered and change one cycle after the edge that captures the input that moves them. `ls_allow` follows `phase_pos` in the same cycle. The bench changes inputs 1 ns after a rising edge and compares every output on the falling edge against a behavioural model that it advances on each rising edge, so every result is sampled in the cycle it is due. The directed checks count falling edges from the returning strobe, so they expect entry one edge after the eighth strobe and the forced request `AUDIO_LIMIT`+1 falling edges after the last one.

// File: rtl/dem_pkg.sv
package dem_pkg;
    typedef enum logic [1:0] {
        ST_FORCED = 2'd0,
        ST_ARMING = 2'd1,
        ST_DIODE  = 2'd2
    } dem_state_e;
endpackage

// File: rtl/dem_streak_ctr.sv
// Counts consecutive positive-polarity strobes and saturates at STREAK_LEN.
module dem_streak_ctr #(
    parameter int STREAK_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(STREAK_LEN + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(STREAK_LEN - 1);
    localparam logic [CW-1:0] FULL_VAL = CW'(STREAK_LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step && (cnt_q != FULL_VAL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/dem_audio_wdog.sv
// Requests an extra pulse once LIMIT cycles pass without a strobe.
module dem_audio_wdog #(
    parameter int LIMIT = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_end,
    output logic force_pulse
);
    localparam int WW = $clog2(LIMIT + 1);
    localparam logic [WW-1:0] TOP_VAL = WW'(LIMIT - 1);

    logic [WW-1:0] gap_q;
    logic          req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            req_q <= 1'b0;
        end else if (pulse_end) begin
            gap_q <= '0;
            req_q <= 1'b0;
        end else if (gap_q == TOP_VAL) begin
            gap_q <= '0;
            req_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
            req_q <= 1'b0;
        end
    end

    always_comb force_pulse = req_q;
endmodule

// File: rtl/dem_mode_fsm.sv
module dem_mode_fsm
    import dem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ccm_lock,
    input  logic pulse_end,
    input  logic phase_pos,
    input  logic streak_last,
    output logic streak_clr,
    output logic streak_step,
    output logic dem_active,
    output logic ls_allow
);
    dem_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMING;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FORCED: if (!ccm_lock) state_d = ST_ARMING;
            ST_ARMING: begin
                if (ccm_lock)                                  state_d = ST_FORCED;
                else if (pulse_end && phase_pos && streak_last) state_d = ST_DIODE;
            end
            ST_DIODE: begin
                if (ccm_lock)                    state_d = ST_FORCED;
                else if (pulse_end && !phase_pos) state_d = ST_ARMING;
            end
            default: state_d = ST_ARMING;
        endcase
    end

    // Outputs
    always_comb begin
        streak_clr  = 1'b1;
        streak_step = 1'b0;
        dem_active  = 1'b0;
        unique case (state_q)
            ST_FORCED: ;
            ST_ARMING: begin
                streak_clr  = ccm_lock || (pulse_end && !phase_pos);
                streak_step = pulse_end && phase_pos;
            end
            ST_DIODE:  dem_active = 1'b1;
            default: ;
        endcase
        ls_allow = !(dem_active && phase_pos);
    end
endmodule

// File: rtl/dem_mode_ctl.sv
module dem_mode_ctl #(
    parameter int STREAK_LEN  = 8,
    parameter int AUDIO_LIMIT = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ccm_lock,
    input  logic pulse_end,
    input  logic phase_pos,
    output logic dem_active,
    output logic ls_allow,
    output logic force_pulse
);
    logic streak_last, streak_clr, streak_step;

    dem_streak_ctr #(.STREAK_LEN(STREAK_LEN)) streak_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (streak_clr),
        .step (streak_step),
        .last (streak_last)
    );

    dem_mode_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ccm_lock   (ccm_lock),
        .pulse_end  (pulse_end),
        .phase_pos  (phase_pos),
        .streak_last(streak_last),
        .streak_clr (streak_clr),
        .streak_step(streak_step),
        .dem_active (dem_active),
        .ls_allow   (ls_allow)
    );

    dem_audio_wdog #(.LIMIT(AUDIO_LIMIT)) wdog_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_end  (pulse_end),
        .force_pulse(force_pulse)
    );
endmodule

// File: rtl/dem_mode_chk.sv
module dem_mode_chk (
    input logic clk,
    input logic rst_n,
    input logic ccm_lock,
    input logic pulse_end,
    input logic phase_pos,
    input logic dem_active,
    input logic ls_allow,
    input logic force_pulse
);
    a_r2_lock_blocks_dem: assert property (@(posedge clk) disable iff (!rst_n)
        ccm_lock |=> !dem_active);
    a_r3_entry_on_pos_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dem_active) |-> $past(pulse_end && phase_pos && !ccm_lock));
    a_r5_exit_on_neg_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_active && pulse_end && !phase_pos) |=> !dem_active);
    a_r6_ls_free_in_ccm: assert property (@(posedge clk) disable iff (!rst_n)
        !dem_active |-> ls_allow);
    a_r8_force_single: assert property (@(posedge clk) disable iff (!rst_n)
        force_pulse |=> !force_pulse);
    a_r9_no_force_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_end |=> !force_pulse);
    a_r10_idle_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_end && !ccm_lock) |=> $stable(dem_active));
endmodule

bind dem_mode_ctl dem_mode_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ccm_lock   (ccm_lock),
    .pulse_end  (pulse_end),
    .phase_pos  (phase_pos),
    .dem_active (dem_active),
    .ls_allow   (ls_allow),
    .force_pulse(force_pulse)
);

// File: tb/dem_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module dem_mode_ctl_tb_top;
    localparam int LIM = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ccm_lock = 1'b0;
    logic pulse_end = 1'b0;
    logic phase_pos = 1'b0;
    logic dem_active, ls_allow, force_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    int  m_mode   = 1;   // 0 forced, 1 arming, 2 diode
    int  m_streak = 0;
    int  m_gap    = 0;
    bit  m_force  = 1'b0;

    always #2.5 clk = ~clk;

    dem_mode_ctl #(.STREAK_LEN(8), .AUDIO_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .ccm_lock(ccm_lock), .pulse_end(pulse_end),
        .phase_pos(phase_pos), .dem_active(dem_active), .ls_allow(ls_allow),
        .force_pulse(force_pulse)
    );

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_streak = 0; m_gap = 0; m_force = 1'b0;
        end else begin
            if (ccm_lock) begin
                m_mode = 0; m_streak = 0;
            end else if (m_mode == 0) begin
                m_mode = 1; m_streak = 0;
            end else if (m_mode == 1) begin
                if (pulse_end) begin
                    if (phase_pos) begin
                        m_streak++;
                        if (m_streak >= 8) begin m_mode = 2; m_streak = 0; end
                    end else m_streak = 0;
                end
            end else if (pulse_end && !phase_pos) begin
                m_mode = 1; m_streak = 0;
            end
            if (pulse_end) begin m_gap = 0; m_force = 1'b0; end
            else if (m_gap == LIM - 1) begin m_gap = 0; m_force = 1'b1; end
            else begin m_gap++; m_force = 1'b0; end
        end
    end

    // lockstep comparison every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 dem_active model", dem_active, m_mode == 2);
            check("R6 ls_allow model", ls_allow, !((m_mode == 2) && phase_pos));
            check("R8 force_pulse model", force_pulse, m_force);
        end
    end

    task automatic strobe(bit pos);
        @(posedge clk); #1;
        pulse_end = 1'b1; phase_pos = pos;
        @(posedge clk); #1;
        pulse_end = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic pos_run(int n);
        for (int i = 0; i < n; i++) begin strobe(1'b1); idle(3); end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset dem_active", dem_active, 1'b0);
        check("R1 reset ls_allow", ls_allow, 1'b1);
        check("R1 reset force_pulse", force_pulse, 1'b0);

        // R2: lock held, positive strobes ignored
        ccm_lock = 1'b1;
        pos_run(10);
        @(negedge clk);
        check("R2 lock keeps ccm", dem_active, 1'b0);
        phase_pos = 1'b1; #0.5;
        check("R2 ls allowed under lock", ls_allow, 1'b1);
        ccm_lock = 1'b0;
        idle(2);

        // R4: streak broken by a negative sample
        pos_run(7);
        strobe(1'b0); idle(3);
        pos_run(7);
        @(negedge clk);
        check("R4 broken streak no entry", dem_active, 1'b0);

        // R3: one more positive completes a fresh streak of eight
        strobe(1'b1);
        @(negedge clk);
        check("R3 entry after eighth", dem_active, 1'b1);

        // R10: phase_pos toggles without strobes
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1; phase_pos = i[0];
        end
        @(negedge clk);
        check("R10 no strobe no change", dem_active, 1'b1);

        // R6: qualifier follows polarity in diode emulation
        @(posedge clk); #1; phase_pos = 1'b1;
        @(negedge clk);
        check("R6 ls blocked on reverse", ls_allow, 1'b0);
        @(posedge clk); #1; phase_pos = 1'b0;
        @(negedge clk);
        check("R6 ls allowed on forward", ls_allow, 1'b1);

        // R5: exit on a single negative strobe, then needs a full streak
        strobe(1'b0);
        @(negedge clk);
        check("R5 exit on negative", dem_active, 1'b0);
        pos_run(7);
        @(negedge clk);
        check("R5 seven not enough", dem_active, 1'b0);
        pos_run(1);
        @(negedge clk);
        check("R5 re-entry on eighth", dem_active, 1'b1);

        // R7: lock while in diode emulation
        @(posedge clk); #1; ccm_lock = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R7 lock exits dem", dem_active, 1'b0);
        @(posedge clk); #1; ccm_lock = 1'b0;
        idle(2);
        pos_run(7);
        @(negedge clk);
        check("R7 streak cleared by lock", dem_active, 1'b0);
        pos_run(1);
        @(negedge clk);
        check("R7 fresh streak enters", dem_active, 1'b1);

        // R9: closely spaced strobes never force
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                strobe(1'b1);
                for (int k = 0; k < LIM - 5; k++) begin
                    @(negedge clk);
                    if (force_pulse) seen++;
                end
            end
            check("R9 no force with dense pulses", seen != 0, 1'b0);
        end

        // R8: forced request after LIM cycles of silence, then periodic
        strobe(1'b1);
        begin
            int n = 0;
            int gap2 = 0;
            do begin @(negedge clk); n++; end while (!force_pulse && n < 4 * LIM);
            check("R8 first force timing", n == LIM + 1, 1'b1);
            @(negedge clk);
            check("R8 force lasts one cycle", force_pulse, 1'b0);
            gap2 = 1;
            do begin @(negedge clk); gap2++; end while (!force_pulse && gap2 < 4 * LIM);
            check("R8 restart period", gap2 == LIM, 1'b1);
        end

        idle(5);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule